// File: doc/BRIEF.md
# Dual-Bank Sector Decoder and Access Guard

This block sits between the host-facing address path of a two-bank flash array and its program, erase and read machinery. Each cycle it turns an incoming word or byte address into a sector number (0 to 70) and a bank number. It combines that result with a stored protection bit per sector, a hardware write-protect pin, a temporary-unprotect input and a per-sector erase-selection mask. From these it decides whether a read may be served from the array and whether a program or erase may start.

The layout has eight 8 KB boot sectors followed by 63 sectors of 64 KB. A build parameter picks bottom-boot, where the boot sectors take the lowest addresses, or top-boot, where they take the highest. In top-boot the numbering is mirrored, so sectors 63 to 70 are the boot sectors. The bank that holds the boot sectors is bank 0, and it spans either 15 or 23 sectors depending on a split input. Bank 1 spans the rest. Protection bits are written through a simple strobe. Erase-mask bits are set while erase commands are collected and cleared all at once when the erase finishes.

Top module: `flash_sector_guard`

## Requirements
- R1: The byte address is {addr_w, addr_lsb} when byte_mode is 1 and {addr_w, 0} when byte_mode is 0. In word mode addr_lsb has no effect on any output.
- R2: Bottom-boot: with B = byte address bits [21:16] and S = bits [15:13], sect_idx is S when B is 0, and B+7 otherwise.
- R3: Top-boot: sect_idx is 63+S when B is 63, and B otherwise.
- R4: bank_id is 0 for the sectors of the boot bank and 1 for all others. The boot bank has 15 sectors when bank_split is 0 and 23 when it is 1. These are sectors 0 to 14 or 0 to 22 in bottom-boot, and sectors 56 to 70 or 48 to 70 in top-boot. sect_idx and bank_id follow the inputs within the same cycle.
- R5: A cycle with prot_wr high loads prot_val into the stored protection bit of the addressed sector. All stored bits are 0 after reset. A sector is locked when its stored bit is 1.
- R6: While temp_unprot is 1, stored protection bits do not lock a sector. The stored bits keep their values and take effect again once temp_unprot returns to 0.
- R7: While wp_n is 0, the two outermost boot sectors are locked regardless of their stored bits or temp_unprot. These are sectors 0 and 1 in bottom-boot and sectors 69 and 70 in top-boot. While wp_n is 1, those sectors follow R5 and R6.
- R8: start_req in a cycle gives, at the next clock edge, start_grant=1 if the addressed sector is unlocked, or a one-cycle start_reject=1 if it is locked. The two outputs are never high together, and both are 0 after a cycle with no start_req.
- R9: erase_mark sets the mask bit of the addressed sector only if that sector is unlocked. erase_clr clears every mask bit and wins over erase_mark in the same cycle. Reset clears the mask.
- R10: rd_req gives rd_grant=1 at the next edge only if the addressed bank's bank_busy bit is 0 and no sector of that bank has its mask bit set. Bank membership is evaluated with the current bank_split.
- R11: While rst_n is 0, rd_grant, start_grant and start_reject are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1: byte addressing, 0: word addressing |
| addr_w | input | 21 | Word address (upper byte-address bits) |
| addr_lsb | input | 1 | Byte-address LSB, used in byte mode only |
| bank_split | input | 1 | Boot bank size: 0 = 15 sectors, 1 = 23 sectors |
| bank_busy | input | 2 | Per-bank program/erase in progress |
| wp_n | input | 1 | Hardware write protect, active low |
| temp_unprot | input | 1 | Temporarily ignore stored protection bits |
| prot_wr | input | 1 | Write strobe for the addressed protection bit |
| prot_val | input | 1 | Value written by prot_wr |
| erase_mark | input | 1 | Mark the addressed sector for erase |
| erase_clr | input | 1 | Clear the whole erase mask |
| rd_req | input | 1 | Read request for the addressed location |
| start_req | input | 1 | Program/erase start request for the addressed sector |
| sect_idx | output | 7 | Decoded sector number |
| bank_id | output | 1 | Decoded bank number |
| rd_grant | output | 1 | Registered read permission |
| start_grant | output | 1 | Registered start permission |
| start_reject | output | 1 | Registered one-cycle reject for a locked target |

## Verification
The assertions assume that the request and control inputs are stable across each clock edge and hold known values whenever rst_n is high. They also assume that bank_busy is driven by the surrounding sequencer independently of the grants. The bench changes every input one time unit after the rising edge, never at the edge itself. It draws control bits with fixed weights, which lets protection writes, erase marks and mask clears occur in the same cycle in every combination. Addresses alternate between random words and a fixed set of sector and bank boundaries in both byte and word mode. The bench also applies one mid-run reset while state is populated.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
   typedef enum logic {
      BOOT_LOW  = 1'b0,
      BOOT_HIGH = 1'b1
   } boot_pos_e;

   localparam int OUTER_LOCKED = 2;
endpackage

// File: rtl/sdg_addr_map.sv
module sdg_addr_map
   import sdg_pkg::*;
#(
   parameter int        ADDR_W      = 22,
   parameter int        BOOT_LOG    = 13,
   parameter int        BIG_LOG     = 16,
   parameter int        BANK0_SMALL = 15,
   parameter int        BANK0_LARGE = 23,
   parameter int        SECT_W      = 7,
   parameter boot_pos_e BOOT_POS    = BOOT_LOW
) (
   input  logic [ADDR_W-1:0] byte_addr,
   input  logic              bank_split,
   output logic [SECT_W-1:0] sect,
   output logic              bank,
   output logic              outer
);
   localparam int N_BOOT = 2 ** (BIG_LOG - BOOT_LOG);
   localparam int N_BIG  = 2 ** (ADDR_W - BIG_LOG);
   localparam int N_SECT = N_BOOT + N_BIG - 1;
   localparam int BW     = ADDR_W - BIG_LOG;
   localparam int SW     = BIG_LOG - BOOT_LOG;

   logic [BW-1:0] big_unit;
   logic [SW-1:0] small_unit;
   int            bank0_cnt;

   assign big_unit   = byte_addr[ADDR_W-1:BIG_LOG];
   assign small_unit = byte_addr[BIG_LOG-1:BOOT_LOG];
   assign bank0_cnt  = bank_split ? BANK0_LARGE : BANK0_SMALL;

   if (BOOT_POS == BOOT_LOW) begin : g_low
      always_comb begin
         if (big_unit == '0) sect = SECT_W'(small_unit);
         else                sect = SECT_W'(big_unit) + SECT_W'(N_BOOT - 1);
         bank  = (int'(sect) >= bank0_cnt);
         outer = (int'(sect) < OUTER_LOCKED);
      end
   end else begin : g_high
      always_comb begin
         if (big_unit == '1) sect = SECT_W'(N_BIG - 1) + SECT_W'(small_unit);
         else                sect = SECT_W'(big_unit);
         bank  = (int'(sect) < N_SECT - bank0_cnt);
         outer = (int'(sect) >= N_SECT - OUTER_LOCKED);
      end
   end
endmodule

// File: rtl/sdg_prot_bits.sv
module sdg_prot_bits #(
   parameter int N_SECT = 71,
   parameter int SECT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_val,
   input  logic [SECT_W-1:0] sel,
   output logic [N_SECT-1:0] bits
);
   for (genvar i = 0; i < N_SECT; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= 1'b0;
         else if (wr_en && sel == SECT_W'(i))     q <= wr_val;
      end
      assign bits[i] = q;
   end

   a_r6_bits_hold_without_write : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bits));
endmodule

// File: rtl/sdg_erase_mask.sv
module sdg_erase_mask
   import sdg_pkg::*;
#(
   parameter int        N_SECT      = 71,
   parameter int        SECT_W      = 7,
   parameter int        BANK0_SMALL = 15,
   parameter int        BANK0_LARGE = 23,
   parameter boot_pos_e BOOT_POS    = BOOT_LOW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mark,
   input  logic              clr,
   input  logic [SECT_W-1:0] sel,
   input  logic              bank_split,
   output logic [1:0]        bank_marked
);
   logic [N_SECT-1:0] mask;
   logic [N_SECT-1:0] in_b0_small;
   logic [N_SECT-1:0] in_b0_large;
   logic [N_SECT-1:0] in_b0;

   for (genvar i = 0; i < N_SECT; i++) begin : g_sect
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           q <= 1'b0;
         else if (clr)                         q <= 1'b0;
         else if (mark && sel == SECT_W'(i))   q <= 1'b1;
      end
      assign mask[i] = q;
      if (BOOT_POS == BOOT_LOW) begin : g_low
         assign in_b0_small[i] = (i < BANK0_SMALL);
         assign in_b0_large[i] = (i < BANK0_LARGE);
      end else begin : g_high
         assign in_b0_small[i] = (i >= N_SECT - BANK0_SMALL);
         assign in_b0_large[i] = (i >= N_SECT - BANK0_LARGE);
      end
   end

   assign in_b0          = bank_split ? in_b0_large : in_b0_small;
   assign bank_marked[0] = |(mask & in_b0);
   assign bank_marked[1] = |(mask & ~in_b0);

   a_r9_clear_empties : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mask == '0));
   a_r9_set_needs_mark : assert property (@(posedge clk) disable iff (!rst_n)
      (!mark && !clr) |=> $stable(mask));
endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard
   import sdg_pkg::*;
#(
   parameter int        ADDR_W      = 22,
   parameter int        BOOT_LOG    = 13,
   parameter int        BIG_LOG     = 16,
   parameter int        BANK0_SMALL = 15,
   parameter int        BANK0_LARGE = 23,
   parameter int        SECT_W      = 7,
   parameter boot_pos_e BOOT_POS    = BOOT_LOW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic [ADDR_W-2:0] addr_w,
   input  logic              addr_lsb,
   input  logic              bank_split,
   input  logic [1:0]        bank_busy,
   input  logic              wp_n,
   input  logic              temp_unprot,
   input  logic              prot_wr,
   input  logic              prot_val,
   input  logic              erase_mark,
   input  logic              erase_clr,
   input  logic              rd_req,
   input  logic              start_req,
   output logic [SECT_W-1:0] sect_idx,
   output logic              bank_id,
   output logic              rd_grant,
   output logic              start_grant,
   output logic              start_reject
);
   localparam int N_BOOT = 2 ** (BIG_LOG - BOOT_LOG);
   localparam int N_BIG  = 2 ** (ADDR_W - BIG_LOG);
   localparam int N_SECT = N_BOOT + N_BIG - 1;

   if (BIG_LOG <= BOOT_LOG || ADDR_W <= BIG_LOG) begin : g_bad_geometry
      $error("sector geometry: need BOOT_LOG < BIG_LOG < ADDR_W");
   end
   if (N_SECT > 2 ** SECT_W) begin : g_bad_sect_w
      $error("SECT_W too narrow for the sector count");
   end
   if (BANK0_SMALL < N_BOOT || BANK0_LARGE <= BANK0_SMALL || BANK0_LARGE >= N_SECT) begin : g_bad_split
      $error("bank split options out of range");
   end

   logic [ADDR_W-1:0] byte_addr;
   logic              outer;
   logic [N_SECT-1:0] prot_bits;
   logic [N_SECT-1:0] sel_vec;
   logic [1:0]        bank_marked;
   logic              stored_lock;
   logic              locked;

   assign byte_addr = byte_mode ? {addr_w, addr_lsb} : {addr_w, 1'b0};

   sdg_addr_map #(
      .ADDR_W(ADDR_W), .BOOT_LOG(BOOT_LOG), .BIG_LOG(BIG_LOG),
      .BANK0_SMALL(BANK0_SMALL), .BANK0_LARGE(BANK0_LARGE),
      .SECT_W(SECT_W), .BOOT_POS(BOOT_POS)
   ) u_map (
      .byte_addr (byte_addr),
      .bank_split(bank_split),
      .sect      (sect_idx),
      .bank      (bank_id),
      .outer     (outer)
   );

   sdg_prot_bits #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_prot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (prot_wr),
      .wr_val(prot_val),
      .sel   (sect_idx),
      .bits  (prot_bits)
   );

   assign sel_vec     = N_SECT'(1) << sect_idx;
   assign stored_lock = |(prot_bits & sel_vec);
   assign locked      = (stored_lock && !temp_unprot) || (!wp_n && outer);

   sdg_erase_mask #(
      .N_SECT(N_SECT), .SECT_W(SECT_W),
      .BANK0_SMALL(BANK0_SMALL), .BANK0_LARGE(BANK0_LARGE), .BOOT_POS(BOOT_POS)
   ) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .mark       (erase_mark && !locked),
      .clr        (erase_clr),
      .sel        (sect_idx),
      .bank_split (bank_split),
      .bank_marked(bank_marked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_grant     <= 1'b0;
         start_grant  <= 1'b0;
         start_reject <= 1'b0;
      end else begin
         rd_grant     <= rd_req && !bank_busy[bank_id] && !bank_marked[bank_id];
         start_grant  <= start_req && !locked;
         start_reject <= start_req && locked;
      end
   end

   a_r2_sect_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      int'(sect_idx) < N_SECT);
   a_r7_wp_blocks_outer : assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !wp_n && outer) |=> (start_reject && !start_grant));
   a_r8_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(start_grant && start_reject));
   a_r8_idle_no_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      !start_req |=> (!start_grant && !start_reject));
   a_r10_busy_bank_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && bank_busy[bank_id]) |=> !rd_grant);
   a_r10_no_request_no_grant : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_grant);
endmodule

// File: tb/test_flash_sector_guard.sv
module test_flash_sector_guard;
   import sdg_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_mode = 1'b0, addr_lsb = 1'b0, bank_split = 1'b0;
   logic [20:0] addr_w = '0;
   logic [1:0]  bank_busy = '0;
   logic        wp_n = 1'b1, temp_unprot = 1'b0, prot_wr = 1'b0, prot_val = 1'b0;
   logic        erase_mark = 1'b0, erase_clr = 1'b0, rd_req = 1'b0, start_req = 1'b0;

   logic [6:0]  sect_o [2];
   logic        bank_o [2];
   logic        rdg_o  [2];
   logic        stg_o  [2];
   logic        rej_o  [2];

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   flash_sector_guard #(.BOOT_POS(BOOT_LOW)) i_flash_sector_guard (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .addr_w(addr_w), .addr_lsb(addr_lsb),
      .bank_split(bank_split), .bank_busy(bank_busy), .wp_n(wp_n), .temp_unprot(temp_unprot),
      .prot_wr(prot_wr), .prot_val(prot_val), .erase_mark(erase_mark), .erase_clr(erase_clr),
      .rd_req(rd_req), .start_req(start_req), .sect_idx(sect_o[0]), .bank_id(bank_o[0]),
      .rd_grant(rdg_o[0]), .start_grant(stg_o[0]), .start_reject(rej_o[0]));

   flash_sector_guard #(.BOOT_POS(BOOT_HIGH)) i_flash_sector_guard_top (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .addr_w(addr_w), .addr_lsb(addr_lsb),
      .bank_split(bank_split), .bank_busy(bank_busy), .wp_n(wp_n), .temp_unprot(temp_unprot),
      .prot_wr(prot_wr), .prot_val(prot_val), .erase_mark(erase_mark), .erase_clr(erase_clr),
      .rd_req(rd_req), .start_req(start_req), .sect_idx(sect_o[1]), .bank_id(bank_o[1]),
      .rd_grant(rdg_o[1]), .start_grant(stg_o[1]), .start_reject(rej_o[1]));

   // reference model state, variant 0 = bottom-boot, 1 = top-boot
   bit prot_m [2][71];
   bit mask_m [2][71];
   bit exp_rd [2];
   bit exp_st [2];
   bit exp_rj [2];

   function automatic int ref_sect(int v);
      int ba, big, sm;
      ba  = int'(addr_w) * 2 + ((byte_mode) ? int'(addr_lsb) : 0);
      big = ba / 65536;
      sm  = (ba / 8192) % 8;
      if (v == 0) return (big == 0) ? sm : 7 + big;
      return (big == 63) ? 63 + sm : big;
   endfunction

   function automatic int ref_bank(int v, int s);
      int n0;
      n0 = bank_split ? 23 : 15;
      if (v == 0) return (s >= n0) ? 1 : 0;
      return (s < 71 - n0) ? 1 : 0;
   endfunction

   function automatic bit ref_outer(int v, int s);
      return (v == 0) ? (s < 2) : (s >= 69);
   endfunction

   always @(posedge clk) begin
      for (int v = 0; v < 2; v++) begin
         if (!rst_n) begin
            for (int i = 0; i < 71; i++) begin
               prot_m[v][i] = 1'b0;
               mask_m[v][i] = 1'b0;
            end
            exp_rd[v] = 1'b0; exp_st[v] = 1'b0; exp_rj[v] = 1'b0;
         end else begin
            int  s, b;
            bit  lock, any;
            s    = ref_sect(v);
            b    = ref_bank(v, s);
            lock = (prot_m[v][s] && !temp_unprot) || (!wp_n && ref_outer(v, s));
            any  = 1'b0;
            for (int i = 0; i < 71; i++)
               if (mask_m[v][i] && ref_bank(v, i) == b) any = 1'b1;
            exp_rd[v] = rd_req && !bank_busy[b] && !any;
            exp_st[v] = start_req && !lock;
            exp_rj[v] = start_req && lock;
            if (prot_wr) prot_m[v][s] = prot_val;
            if (erase_clr) begin
               for (int i = 0; i < 71; i++) mask_m[v][i] = 1'b0;
            end else if (erase_mark && !lock) begin
               mask_m[v][s] = 1'b1;
            end
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      for (int v = 0; v < 2; v++) begin
         int s;
         s = ref_sect(v);
         if (v == 0) chk("R1 R2 sect bottom", int'(sect_o[v]), s);
         else        chk("R1 R3 sect top", int'(sect_o[v]), s);
         chk("R4 bank", int'(bank_o[v]), ref_bank(v, s));
         if (!rst_n) begin
            chk("R11 rd_grant in reset", int'(rdg_o[v]), 0);
            chk("R11 start_grant in reset", int'(stg_o[v]), 0);
            chk("R11 start_reject in reset", int'(rej_o[v]), 0);
         end else begin
            chk("R9 R10 rd_grant", int'(rdg_o[v]), int'(exp_rd[v]));
            chk("R5 R6 R7 R8 start_grant", int'(stg_o[v]), int'(exp_st[v]));
            chk("R8 start_reject", int'(rej_o[v]), int'(exp_rj[v]));
         end
      end
   end

   function automatic logic [20:0] edge_addr(int k);
      case (k % 16)
         0:  return 21'h000000;
         1:  return 21'h000FFF;
         2:  return 21'h001000;
         3:  return 21'h007FFF;
         4:  return 21'h008000;
         5:  return 21'h03FFFF;
         6:  return 21'h040000;
         7:  return 21'h078000;
         8:  return 21'h0B8000;
         9:  return 21'h0C0000;
         10: return 21'h1BFFFF;
         11: return 21'h1F7FFF;
         12: return 21'h1F8000;
         13: return 21'h1FAFFF;
         14: return 21'h1FF000;
         default: return 21'h1FFFFF;
      endcase
   endfunction

   task automatic step_random(int k, int p_clr);
      @(posedge clk); #1;
      addr_w      = (($urandom % 2) == 0) ? edge_addr(int'($urandom % 16)) : 21'($urandom);
      byte_mode   = 1'($urandom);
      addr_lsb    = 1'($urandom);
      bank_split  = (($urandom % 8) == 0) ? ~bank_split : bank_split;
      bank_busy   = {1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0)};
      wp_n        = (($urandom % 3) != 0);
      temp_unprot = (($urandom % 4) == 0);
      prot_wr     = (($urandom % 5) == 0);
      prot_val    = (($urandom % 3) != 0);
      erase_mark  = (($urandom % 6) == 0);
      erase_clr   = (int'($urandom % 100) < p_clr);
      rd_req      = 1'($urandom);
      start_req   = 1'($urandom);
      if (k < 0) addr_w = 21'h0;
   endtask

   initial begin
      // reset phase (R11)
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // directed boundary sweep: word and byte mode, no state change (R1-R4)
      for (int k = 0; k < 64; k++) begin
         @(posedge clk); #1;
         addr_w = edge_addr(k); byte_mode = k[4]; addr_lsb = k[5];
         bank_split = k[0]; rd_req = 1'b1; start_req = 1'b1;
      end
      // protect outer boot sectors then probe with wp_n and temp_unprot (R5-R7)
      for (int k = 0; k < 32; k++) begin
         @(posedge clk); #1;
         addr_w = edge_addr(k % 4 == 0 ? 0 : 15); byte_mode = 1'b0;
         prot_wr = (k < 2); prot_val = 1'b1; start_req = 1'b1;
         wp_n = k[2]; temp_unprot = k[3]; erase_mark = k[4];
      end
      prot_wr = 1'b0; erase_mark = 1'b0;
      // random traffic with frequent and rare mask clears (R8-R10)
      for (int k = 0; k < 3000; k++) step_random(k, 5);
      for (int k = 0; k < 1500; k++) step_random(k, 1);
      // mid-run reset with populated state (R11), then more traffic
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int k = 0; k < 1500; k++) step_random(k, 3);
      @(posedge clk); #1;
      rd_req = 1'b0; start_req = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule